// File: doc/BRIEF.md
# Hardware Loop Sequencer with Pixel Pointer Generator

This block lets a pipelined image processor run its per-pixel kernel without spending any instruction on loop control or address arithmetic. Before the kernel starts, a setup instruction hands the block three values: how many times to run the body (normally the pixel count of the frame), the first body address and the last body address. After that the block watches the fetch address. Each time fetch reaches the last body address with more than one pass left, the block sends fetch back to the first body address in the same cycle. There is no compare and no branch inside the loop, so the pipeline never flushes. On the final pass, fetch continues to the address after the body.

Next to the sequencer sit two pixel pointers, one for each data memory (X and Y). A pointer is configured with a base address and a frame length. A data instruction that carries the update extension makes the pointer step by one, at the same time as the access that uses the current address. After the last position of the frame, the pointer returns to its base.

Top module: `pixel_loop_agen`

## Requirements
- R1: After reset, `loop_active` and `redirect` are 0, `iter_left` is 0, both pointer addresses are 0, and `next_pc` equals `fetch_pc + 1`.
- R2: A cycle with `setup_valid` high and a nonzero `setup_count` loads the count, start and end. From the next cycle on, `iter_left` equals that count and `loop_active` is 1.
- R3: A valid fetch at the end address, while active with `iter_left` greater than 1, makes `redirect` 1 and `next_pc` equal the start address in that same cycle. `iter_left` drops by one in the next cycle.
- R4: A valid fetch at the end address, while active with `iter_left` equal to 1, gives `redirect` 0 and `next_pc` equal to end + 1. In the next cycle `iter_left` is 0 and `loop_active` is 0.
- R5: Any other fetch, or any cycle with `fetch_valid` low, gives `next_pc = fetch_pc + 1` and `redirect` 0, and `iter_left` does not change.
- R6: A setup with count 0 leaves `loop_active` at 0 and arms a skip. The next valid fetch at the start address gives `next_pc` equal to end + 1. The skip then clears, so a later fetch at the start address gives start + 1.
- R7: When `setup_valid` is high while a loop is running, the new parameters replace the old ones. If the same cycle is a redirect, that cycle still redirects using the old parameters, but the new count wins over the decrement.
- R8: `ptr_upd[0]` (X) and `ptr_upd[1]` (Y) each advance their own pointer address by 1 in the next cycle. Without the flag and without a configure write, the address holds.
- R9: A pointer that has been advanced frame-length times from its base is back at its base. With a frame length of 0 the pointer stays at its base.
- R10: `ptr_cfg_we` with `ptr_cfg_sel` = 0 (X) or 1 (Y) writes the base and length of that pointer only, and resets its address to the new base in the next cycle. A configure write wins over an update to the same pointer in the same cycle.
- R11: The count is 20 bits wide. A full 640x480 frame count of 307200 loads as is and counts down by one per redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| setup_valid | input | 1 | Loop setup instruction in this cycle |
| setup_count | input | CNT_W | Number of passes through the body |
| setup_start | input | PC_W | First body address |
| setup_end | input | PC_W | Last body address |
| fetch_valid | input | 1 | Fetch advances in this cycle |
| fetch_pc | input | PC_W | Address being fetched |
| next_pc | output | PC_W | Address to fetch next |
| redirect | output | 1 | Backward jump taken in this cycle |
| loop_active | output | 1 | A loop with passes left is running |
| iter_left | output | CNT_W | Passes left, counting the current one |
| ptr_cfg_we | input | 1 | Configure write to a pointer |
| ptr_cfg_sel | input | 1 | Pointer selected for the write: 0 is X, 1 is Y |
| ptr_cfg_base | input | ADDR_W | Base address to load |
| ptr_cfg_len | input | ADDR_W | Frame length to load |
| ptr_upd | input | 2 | Update flags: bit 0 is X, bit 1 is Y |
| ptr_addr_x | output | ADDR_W | Current X memory address |
| ptr_addr_y | output | ADDR_W | Current Y memory address |

## Verification
A wrong pass count first shows at the end address. The jump back is either missing or made once too often, and `next_pc` is wrong in that same cycle, while `iter_left` is wrong already one cycle after the fault. A wrong start or end register shows as a wrong `next_pc` on the next fetch of the end address. A lost skip flag shows when fetch reaches the start address after a zero-count setup. A pointer with a wrong offset or length shows on its address output one cycle after the next update, or at the latest when the wrap should happen.

// File: rtl/loop_agen_pkg.sv
// Shared definitions for the loop sequencer and the pixel pointer generator.
// Assumes: pointer selection is a single bit, with X memory at index 0.
package loop_agen_pkg;

    // Identifies which data-memory pointer a configure write targets
    typedef enum logic {
        PTR_X = 1'b0,
        PTR_Y = 1'b1
    } ptr_sel_e;

    localparam int NUM_PTRS = 2;

endpackage

// File: rtl/loop_seq.sv
// Hardware loop sequencer. It holds the pass count and the body bounds,
// and computes the next fetch address from the current one.
// Assumes: loops are not nested. A setup always replaces the running loop.
//          A count of zero arms a one-time skip of the body.
module loop_seq #(
    parameter int PC_W  = 16,
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             setup_valid,
    input  logic [CNT_W-1:0] setup_count,
    input  logic [PC_W-1:0]  setup_start,
    input  logic [PC_W-1:0]  setup_end,
    input  logic             fetch_valid,
    input  logic [PC_W-1:0]  fetch_pc,
    output logic [PC_W-1:0]  next_pc,
    output logic             redirect,
    output logic             loop_active,
    output logic [CNT_W-1:0] iter_left
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [PC_W-1:0]  PC_ONE  = PC_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic [PC_W-1:0]  start_q;
    logic [PC_W-1:0]  end_q;
    logic             active_q;
    logic             skip_q;

    logic at_end;
    logic last_pass;
    logic skip_hit;

    // Decode the fetch against the loop bounds
    always_comb begin
        at_end    = fetch_valid && active_q && (fetch_pc == end_q);
        redirect  = at_end && (cnt_q > CNT_ONE);
        last_pass = at_end && (cnt_q == CNT_ONE);
        skip_hit  = fetch_valid && skip_q && (fetch_pc == start_q);
    end

    // Pick the next fetch address
    always_comb begin
        if (redirect) begin
            next_pc = start_q;
        end else if (skip_hit) begin
            next_pc = end_q + PC_ONE;
        end else begin
            next_pc = fetch_pc + PC_ONE;
        end
    end

    // Loop parameter and pass-count registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            start_q  <= '0;
            end_q    <= '0;
            active_q <= 1'b0;
            skip_q   <= 1'b0;
        end else if (setup_valid) begin
            cnt_q    <= setup_count;
            start_q  <= setup_start;
            end_q    <= setup_end;
            active_q <= (setup_count != '0);
            skip_q   <= (setup_count == '0);
        end else begin
            if (redirect) begin
                cnt_q <= cnt_q - CNT_ONE;
            end
            if (last_pass) begin
                cnt_q    <= '0;
                active_q <= 1'b0;
            end
            if (skip_hit) begin
                skip_q <= 1'b0;
            end
        end
    end

    assign loop_active = active_q;
    assign iter_left   = cnt_q;

endmodule

// File: rtl/pixel_ptr.sv
// One pixel pointer. It gives base + offset as the address of the current
// access, and the offset steps when the update flag is set.
// Assumes: the offset returns to zero once it reaches the frame length.
//          A length of zero keeps the pointer at its base.
module pixel_ptr #(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [ADDR_W-1:0] cfg_len,
    input  logic              upd,
    output logic [ADDR_W-1:0] addr
);

    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] len_q;
    logic [ADDR_W-1:0] off_q;
    logic [ADDR_W:0]   off_inc;
    logic              wrap;

    // Next offset, computed one bit wider so the compare cannot overflow
    always_comb begin
        off_inc = {1'b0, off_q} + (ADDR_W+1)'(1);
        wrap    = (off_inc >= {1'b0, len_q});
    end

    // Base, length and offset registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            len_q  <= '0;
            off_q  <= '0;
        end else if (cfg_we) begin
            base_q <= cfg_base;
            len_q  <= cfg_len;
            off_q  <= '0;
        end else if (upd) begin
            off_q <= wrap ? '0 : off_inc[ADDR_W-1:0];
        end
    end

    assign addr = base_q + off_q;

endmodule

// File: rtl/pixel_loop_agen.sv
// Top level: the loop sequencer plus one pixel pointer for each data memory.
// Assumes: update flags come from the decoded data instruction in the same
//          cycle as the access that uses the current pointer address.
module pixel_loop_agen
    import loop_agen_pkg::*;
#(
    parameter int PC_W   = 16,
    parameter int CNT_W  = 20,
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              setup_valid,
    input  logic [CNT_W-1:0]  setup_count,
    input  logic [PC_W-1:0]   setup_start,
    input  logic [PC_W-1:0]   setup_end,
    input  logic              fetch_valid,
    input  logic [PC_W-1:0]   fetch_pc,
    output logic [PC_W-1:0]   next_pc,
    output logic              redirect,
    output logic              loop_active,
    output logic [CNT_W-1:0]  iter_left,
    input  logic              ptr_cfg_we,
    input  logic              ptr_cfg_sel,
    input  logic [ADDR_W-1:0] ptr_cfg_base,
    input  logic [ADDR_W-1:0] ptr_cfg_len,
    input  logic [1:0]        ptr_upd,
    output logic [ADDR_W-1:0] ptr_addr_x,
    output logic [ADDR_W-1:0] ptr_addr_y
);

    ptr_sel_e          sel;
    logic [ADDR_W-1:0] addr_arr [NUM_PTRS];

    // Turn the select pin into the pointer enum
    always_comb sel = ptr_sel_e'(ptr_cfg_sel);

    loop_seq #(
        .PC_W  (PC_W),
        .CNT_W (CNT_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .setup_valid (setup_valid),
        .setup_count (setup_count),
        .setup_start (setup_start),
        .setup_end   (setup_end),
        .fetch_valid (fetch_valid),
        .fetch_pc    (fetch_pc),
        .next_pc     (next_pc),
        .redirect    (redirect),
        .loop_active (loop_active),
        .iter_left   (iter_left)
    );

    for (genvar i = 0; i < NUM_PTRS; i++) begin : g_ptr
        pixel_ptr #(
            .ADDR_W (ADDR_W)
        ) u_ptr (
            .clk      (clk),
            .rst_n    (rst_n),
            .cfg_we   (ptr_cfg_we && (sel == ptr_sel_e'(i))),
            .cfg_base (ptr_cfg_base),
            .cfg_len  (ptr_cfg_len),
            .upd      (ptr_upd[i]),
            .addr     (addr_arr[i])
        );
    end

    assign ptr_addr_x = addr_arr[PTR_X];
    assign ptr_addr_y = addr_arr[PTR_Y];

endmodule

// File: rtl/pixel_loop_agen_chk.sv
// Property checker attached to pixel_loop_agen through bind.
// Assumes: only the ports of the top module are observed.
module pixel_loop_agen_chk #(
    parameter int PC_W   = 16,
    parameter int CNT_W  = 20,
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              setup_valid,
    input logic [CNT_W-1:0]  setup_count,
    input logic [PC_W-1:0]   next_pc,
    input logic [PC_W-1:0]   fetch_pc,
    input logic              redirect,
    input logic              loop_active,
    input logic [CNT_W-1:0]  iter_left,
    input logic              ptr_cfg_we,
    input logic              ptr_cfg_sel,
    input logic [1:0]        ptr_upd,
    input logic [ADDR_W-1:0] ptr_addr_x,
    input logic [ADDR_W-1:0] ptr_addr_y
);

    // R2
    active_has_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        loop_active |-> (iter_left != '0));

    // R7
    setup_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        setup_valid |=> (iter_left == $past(setup_count))
                        && (loop_active == ($past(setup_count) != '0)));

    // R3
    redirect_needs_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> loop_active);

    // R3
    redirect_decrement_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect && !setup_valid) |=> (iter_left == $past(iter_left) - CNT_W'(1)));

    // R4
    exit_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(loop_active) |-> (iter_left == '0));

    // R5
    no_jump_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!redirect && loop_active) |-> (next_pc == fetch_pc + PC_W'(1)) || (next_pc != fetch_pc + PC_W'(1) && !loop_active) || (next_pc == fetch_pc + PC_W'(1)));

    // R8
    ptr_hold_x_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ptr_upd[0] && !(ptr_cfg_we && !ptr_cfg_sel)) |=> $stable(ptr_addr_x));

    // R8
    ptr_hold_y_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ptr_upd[1] && !(ptr_cfg_we && ptr_cfg_sel)) |=> $stable(ptr_addr_y));

endmodule

bind pixel_loop_agen pixel_loop_agen_chk #(
    .PC_W   (PC_W),
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .setup_valid (setup_valid),
    .setup_count (setup_count),
    .next_pc     (next_pc),
    .fetch_pc    (fetch_pc),
    .redirect    (redirect),
    .loop_active (loop_active),
    .iter_left   (iter_left),
    .ptr_cfg_we  (ptr_cfg_we),
    .ptr_cfg_sel (ptr_cfg_sel),
    .ptr_upd     (ptr_upd),
    .ptr_addr_x  (ptr_addr_x),
    .ptr_addr_y  (ptr_addr_y)
);

// File: tb/pixel_loop_agen_tb_top.sv
`timescale 1ns/1ps
// Bench for pixel_loop_agen: directed corner cases, then seeded random
// traffic, all compared against a reference model kept in the bench.
module pixel_loop_agen_tb_top;

    localparam int PC_W   = 16;
    localparam int CNT_W  = 20;
    localparam int ADDR_W = 20;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              setup_valid;
    logic [CNT_W-1:0]  setup_count;
    logic [PC_W-1:0]   setup_start;
    logic [PC_W-1:0]   setup_end;
    logic              fetch_valid;
    logic [PC_W-1:0]   fetch_pc;
    logic [PC_W-1:0]   next_pc;
    logic              redirect;
    logic              loop_active;
    logic [CNT_W-1:0]  iter_left;
    logic              ptr_cfg_we;
    logic              ptr_cfg_sel;
    logic [ADDR_W-1:0] ptr_cfg_base;
    logic [ADDR_W-1:0] ptr_cfg_len;
    logic [1:0]        ptr_upd;
    logic [ADDR_W-1:0] ptr_addr_x;
    logic [ADDR_W-1:0] ptr_addr_y;

    always #2 clk = ~clk;

    pixel_loop_agen #(.PC_W(PC_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .setup_valid(setup_valid), .setup_count(setup_count),
        .setup_start(setup_start), .setup_end(setup_end),
        .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
        .next_pc(next_pc), .redirect(redirect),
        .loop_active(loop_active), .iter_left(iter_left),
        .ptr_cfg_we(ptr_cfg_we), .ptr_cfg_sel(ptr_cfg_sel),
        .ptr_cfg_base(ptr_cfg_base), .ptr_cfg_len(ptr_cfg_len),
        .ptr_upd(ptr_upd), .ptr_addr_x(ptr_addr_x), .ptr_addr_y(ptr_addr_y)
    );

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    // Reference model state
    logic [CNT_W-1:0]  m_cnt;
    logic [PC_W-1:0]   m_start, m_end;
    logic              m_active, m_skip;
    logic [ADDR_W-1:0] m_base [2];
    logic [ADDR_W-1:0] m_len  [2];
    logic [ADDR_W-1:0] m_off  [2];
    logic [PC_W-1:0]   m_pc_next;

    task automatic check(input string req, input string what,
                         input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic void model_reset();
        m_cnt = '0; m_start = '0; m_end = '0; m_active = 1'b0; m_skip = 1'b0;
        for (int i = 0; i < 2; i++) begin
            m_base[i] = '0; m_len[i] = '0; m_off[i] = '0;
        end
    endfunction

    // One cycle: check outputs for the driven inputs, advance the model,
    // and move on to the next falling edge. Empty tags pick one from the case.
    task automatic step(input string tl, input string tp);
        logic           at_end, e_red, e_last, e_skip;
        logic [PC_W-1:0] e_next;
        string          tagl;
        #1;
        at_end = fetch_valid && m_active && (fetch_pc == m_end);
        e_red  = at_end && (m_cnt > 1);
        e_last = at_end && (m_cnt == 1);
        e_skip = fetch_valid && m_skip && (fetch_pc == m_start);
        e_next = e_red ? m_start : (e_skip ? PC_W'(m_end + 1) : PC_W'(fetch_pc + 1));
        tagl = tl;
        if (tagl == "") tagl = e_red ? "R3" : (e_last ? "R4" : (e_skip ? "R6" : "R5"));
        check(tagl, "next_pc", next_pc, e_next);
        check(tagl, "redirect", redirect, e_red);
        check(tagl, "loop_active", loop_active, m_active);
        check(tagl, "iter_left", iter_left, m_cnt);
        check(tp, "ptr_addr_x", ptr_addr_x, ADDR_W'(m_base[0] + m_off[0]));
        check(tp, "ptr_addr_y", ptr_addr_y, ADDR_W'(m_base[1] + m_off[1]));
        m_pc_next = e_next;
        // model update at the coming rising edge
        if (setup_valid) begin
            m_cnt = setup_count; m_start = setup_start; m_end = setup_end;
            m_active = (setup_count != 0); m_skip = (setup_count == 0);
        end else begin
            if (e_red)  m_cnt = m_cnt - 1;
            if (e_last) begin m_cnt = '0; m_active = 1'b0; end
            if (e_skip) m_skip = 1'b0;
        end
        for (int i = 0; i < 2; i++) begin
            if (ptr_cfg_we && (ptr_cfg_sel == 1'(i))) begin
                m_base[i] = ptr_cfg_base; m_len[i] = ptr_cfg_len; m_off[i] = '0;
            end else if (ptr_upd[i]) begin
                m_off[i] = ((m_off[i] + 1) >= m_len[i]) ? '0 : ADDR_W'(m_off[i] + 1);
            end
        end
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        setup_valid = 1'b0; setup_count = '0; setup_start = '0; setup_end = '0;
        fetch_valid = 1'b0; fetch_pc = '0;
        ptr_cfg_we = 1'b0; ptr_cfg_sel = 1'b0; ptr_cfg_base = '0; ptr_cfg_len = '0;
        ptr_upd = 2'b00;
    endtask

    task automatic setup(input int cnt, input int st, input int en);
        setup_valid = 1'b1; setup_count = CNT_W'(cnt);
        setup_start = PC_W'(st); setup_end = PC_W'(en);
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        idle_inputs();
        model_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        fetch_pc = 16'd7;
        step("R1", "R1");

        // R2 load, then R3 / R4 passes of a 3-pass loop on 10..12
        setup(3, 10, 12); fetch_valid = 1'b1; fetch_pc = 16'd9;
        step("R2", "R8");
        setup_valid = 1'b0;
        for (int k = 0; k < 11; k++) begin
            fetch_pc = m_pc_next;
            step("", "R8");
        end

        // R5 stalled fetch at end address keeps count
        setup(2, 30, 31); fetch_pc = 16'd29; step("R2", "R8");
        setup_valid = 1'b0; fetch_valid = 1'b0; fetch_pc = 16'd31; step("R5", "R8");
        fetch_valid = 1'b1; step("R3", "R8");
        fetch_pc = 16'd31; step("R4", "R8");

        // R11 full-frame count on a one-word body, then R7 overwrite during redirect
        setup(307200, 0, 0); fetch_pc = 16'd5; step("R11", "R8");
        setup_valid = 1'b0; fetch_pc = 16'd0;
        repeat (4) step("R11", "R8");
        setup(2, 40, 41); step("R7", "R8");
        setup_valid = 1'b0; fetch_pc = 16'd41; step("R7", "R8");
        step("R7", "R8");

        // R6 zero-count skip, then disarmed
        setup(0, 20, 25); fetch_pc = 16'd19; step("R6", "R8");
        setup_valid = 1'b0; fetch_pc = 16'd20; step("R6", "R8");
        fetch_pc = 16'd20; step("R6", "R8");

        // R9 / R10 pointers: X base 100 len 3, Y base 500 len 0
        fetch_valid = 1'b0;
        ptr_cfg_we = 1'b1; ptr_cfg_sel = 1'b0; ptr_cfg_base = 20'd100; ptr_cfg_len = 20'd3;
        ptr_upd = 2'b01; step("R10", "R10");
        ptr_cfg_sel = 1'b1; ptr_cfg_base = 20'd500; ptr_cfg_len = 20'd0; ptr_upd = 2'b00;
        step("R10", "R10");
        ptr_cfg_we = 1'b0; ptr_upd = 2'b11;
        repeat (5) step("R8", "R9");
        ptr_upd = 2'b00; step("R8", "R8");

        // Random traffic
        for (int k = 0; k < 4000; k++) begin
            setup_valid = ($urandom % 40) == 0;
            setup_count = (($urandom % 10) == 0) ? CNT_W'($urandom) : CNT_W'($urandom % 5);
            setup_start = PC_W'($urandom % 32);
            setup_end   = PC_W'(setup_start + ($urandom % 4));
            fetch_valid = ($urandom % 4) != 0;
            fetch_pc    = (($urandom % 5) != 0) ? m_pc_next : PC_W'($urandom % 40);
            ptr_cfg_we  = ($urandom % 50) == 0;
            ptr_cfg_sel = 1'($urandom);
            ptr_cfg_base = ADDR_W'($urandom % 4096);
            ptr_cfg_len  = ADDR_W'($urandom % 9);
            ptr_upd      = 2'($urandom);
            step("", "R8");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL R1 watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule